// File: doc/BRIEF.md
# Dual-Mode Paged Register Decoder

This block turns host register accesses into one-hot register selects for a bus controller that can present either of two legacy register maps. Each map is eight bytes wide and is reached through a 3-bit address with separate read and write strobes. Both maps have more registers than eight offsets can hold. The extra registers are reached through a page-in mechanism, and that mechanism behaves differently in each mode.

In mode A (`mode_b` low), the extended page is open while the page-in pin is high. It can also be opened by an auxiliary page-in command, which then serves exactly one later access. A DMA access counts as an access and uses that page. In mode B (`mode_b` high), the page-in pin has no effect. Four auxiliary commands each map one of four writable registers onto offset 2. The selection stays until a different page command or the clear command arrives. While a register is mapped there, reads at offsets 4 and 5 return the second interrupt status and the serial poll status, and `acc_en` is high. The register contents live outside this block. The auxiliary command input is the decoded command code, presented in the same cycle as the host write that carries it.

Top module: `dual_map_regsel`

## Requirements
- R1: `rd_sel` and `wr_sel` are one-hot or zero, and zero whenever their strobe is low. `rd_sel` bit order: 0 data-in, 1 int-status-0, 2 int-status-1, 3 int-status-2, 4 serial-poll-status, 5 addr-status, 6 cmd-pass, 7 addr-0, 8 addr-1, 9 key-status, 10 second-addr-status, 11 bus-status. `wr_sel` bit order: 0 data-out, 1 int-mask-0, 2 int-mask-1, 3 int-mask-2, 4 serial-poll-mode, 5 addr-mode, 6 aux, 7 addr, 8 end-string, 9 key-ctrl, 10 bus-ctrl, 11 par-poll, 12 accessory.
- R2: Mode A with no page open, offsets 0..7: reads select bits 0,2,3,4,5,6,7,8 and writes select bits 0,2,3,4,5,6,7,8.
- R3: Mode A with a page open: offsets 3,5,6,7 read bits 9,10,1,11 and write bits 9,6,1,10. Offsets 0,1,2,4 decode as in R2.
- R4: In mode A the page is open in every cycle in which `page_pin` is high.
- R5: In mode A, an aux write with code 1 opens the page for the next read, write or DMA access after the command cycle. That access, including one made by DMA alone, closes it again. Until that access arrives, the page stays open.
- R6: Mode B with no page mapped, offsets 0..7: reads select bits 1,2,5,11,none,none,6,0 and writes select bits 1,2,none,6,7,4,11,0.
- R7: In mode B, `page_pin` has no effect on any select.
- R8: In mode B, aux codes 4,5,6,7 map write bit 3,8,10,12 respectively onto offset 2. The mapping holds across any number of accesses. While a register is mapped, reads at offsets 4 and 5 select bits 3 and 4.
- R9: In mode B, aux code 2 removes the mapping. A later page code replaces the earlier one. A new mapping takes effect from the cycle after its command.
- R10: `acc_en` is high exactly when `mode_b` is high and a register is mapped at offset 2.
- R11: Reset closes the mode A page and removes the mode B mapping, so `acc_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b | input | 1 | 0 selects map A, 1 selects map B |
| addr | input | 3 | Host register offset |
| rd_stb | input | 1 | Host read strobe, one cycle per access |
| wr_stb | input | 1 | Host write strobe, one cycle per access |
| dma_stb | input | 1 | DMA access strobe |
| page_pin | input | 1 | Page-in pin, effective in mode A only |
| aux_wr | input | 1 | Auxiliary command write |
| aux_code | input | 3 | Auxiliary command code (1 page A, 2 clear B, 4..7 map slot B) |
| rd_sel | output | 12 | One-hot read register select |
| wr_sel | output | 13 | One-hot write register select |
| acc_en | output | 1 | Register mapped at offset 2 in mode B |

## Verification
The decoder is driven with random mixes of reads, writes, DMA strobes, pin levels, auxiliary codes and occasional mode flips. Each cycle's selects are compared with table lookups driven by a bench model of the page state. Directed sequences separate the pin from the one-shot command in mode A. They show that a DMA strobe alone uses up the command, and that a command followed by idle cycles keeps the page open. In mode B they show that the pin changes nothing, that a mapping lasts across several accesses, that a later code replaces an earlier one, and that the clear code removes the mapping. A mid-run reset with both pages dirty shows that every page state is cleared.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int ADDR_W  = 3;
  localparam int CODE_W  = 3;
  localparam int N_RD    = 12;
  localparam int N_WR    = 13;
  localparam int SLOT_W  = 2;
  localparam int RIDX_W  = $clog2(N_RD);
  localparam int WIDX_W  = $clog2(N_WR);

  // read register indices (bit positions of rd_sel)
  localparam int R_DIN  = 0;
  localparam int R_IST0 = 1;
  localparam int R_IST1 = 2;
  localparam int R_IST2 = 3;
  localparam int R_SPST = 4;
  localparam int R_ADST = 5;
  localparam int R_CPT  = 6;
  localparam int R_AD0  = 7;
  localparam int R_AD1  = 8;
  localparam int R_KST  = 9;
  localparam int R_SAST = 10;
  localparam int R_BST  = 11;

  // write register indices (bit positions of wr_sel)
  localparam int W_DOUT = 0;
  localparam int W_IMK0 = 1;
  localparam int W_IMK1 = 2;
  localparam int W_IMK2 = 3;
  localparam int W_SPMD = 4;
  localparam int W_ADMD = 5;
  localparam int W_AUX  = 6;
  localparam int W_ADR  = 7;
  localparam int W_EOS  = 8;
  localparam int W_KCT  = 9;
  localparam int W_BCT  = 10;
  localparam int W_PPL  = 11;
  localparam int W_ACC  = 12;

  // auxiliary command codes
  localparam logic [CODE_W-1:0] AUX_PAGE_A = 3'd1;
  localparam logic [CODE_W-1:0] AUX_CLR_B  = 3'd2;

  typedef struct packed {
    logic              hit;
    logic [RIDX_W-1:0] idx;
  } rd_hit_t;

  typedef struct packed {
    logic              hit;
    logic [WIDX_W-1:0] idx;
  } wr_hit_t;

  function automatic rd_hit_t mk_rd(input int i);
    rd_hit_t r;
    r.hit = 1'b1;
    r.idx = RIDX_W'(i);
    return r;
  endfunction

  function automatic wr_hit_t mk_wr(input int i);
    wr_hit_t w;
    w.hit = 1'b1;
    w.idx = WIDX_W'(i);
    return w;
  endfunction

  // a code in the upper half names a mode B slot
  function automatic logic is_slot_code(input logic [CODE_W-1:0] c);
    return c[CODE_W-1];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [CODE_W-1:0] c);
    return c[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/dms_page_a.sv
// Mode A page state: one-shot command flag plus the pin.
module dms_page_a
  import dms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_b,
  input  logic              page_pin,
  input  logic              any_acc,
  input  logic              aux_wr,
  input  logic [CODE_W-1:0] aux_code,
  output logic              cmd_q,
  output logic              page_open
);
  logic set_cmd;

  assign set_cmd = aux_wr && !mode_b && (aux_code == AUX_PAGE_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_q <= 1'b0;
    else if (mode_b)  cmd_q <= 1'b0;
    else if (set_cmd) cmd_q <= 1'b1;
    else if (any_acc) cmd_q <= 1'b0;
  end

  assign page_open = !mode_b && (page_pin || cmd_q);
endmodule

// File: rtl/dms_page_b.sv
// Mode B page state: persistent slot selection for offset 2.
module dms_page_b
  import dms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_b,
  input  logic              aux_wr,
  input  logic [CODE_W-1:0] aux_code,
  output logic              slot_vld,
  output logic [SLOT_W-1:0] slot
);
  logic do_page, do_clr;

  assign do_page = aux_wr && mode_b && is_slot_code(aux_code);
  assign do_clr  = aux_wr && mode_b && (aux_code == AUX_CLR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= 1'b0;
      slot     <= '0;
    end else if (do_page) begin
      slot_vld <= 1'b1;
      slot     <= slot_of(aux_code);
    end else if (do_clr) begin
      slot_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/dms_map_a.sv
// Offset decode of map A.
module dms_map_a
  import dms_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_open,
  output rd_hit_t           rd,
  output wr_hit_t           wr
);
  function automatic rd_hit_t rd_a(input logic [ADDR_W-1:0] a, input logic pg);
    case (a)
      3'd0:    return mk_rd(R_DIN);
      3'd1:    return mk_rd(R_IST1);
      3'd2:    return mk_rd(R_IST2);
      3'd3:    return pg ? mk_rd(R_KST)  : mk_rd(R_SPST);
      3'd4:    return mk_rd(R_ADST);
      3'd5:    return pg ? mk_rd(R_SAST) : mk_rd(R_CPT);
      3'd6:    return pg ? mk_rd(R_IST0) : mk_rd(R_AD0);
      default: return pg ? mk_rd(R_BST)  : mk_rd(R_AD1);
    endcase
  endfunction

  function automatic wr_hit_t wr_a(input logic [ADDR_W-1:0] a, input logic pg);
    case (a)
      3'd0:    return mk_wr(W_DOUT);
      3'd1:    return mk_wr(W_IMK1);
      3'd2:    return mk_wr(W_IMK2);
      3'd3:    return pg ? mk_wr(W_KCT)  : mk_wr(W_SPMD);
      3'd4:    return mk_wr(W_ADMD);
      3'd5:    return mk_wr(W_AUX);
      3'd6:    return pg ? mk_wr(W_IMK0) : mk_wr(W_ADR);
      default: return pg ? mk_wr(W_BCT)  : mk_wr(W_EOS);
    endcase
  endfunction

  assign rd = rd_a(addr, page_open);
  assign wr = wr_a(addr, page_open);
endmodule

// File: rtl/dms_map_b.sv
// Offset decode of map B.
module dms_map_b
  import dms_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              slot_vld,
  input  logic [SLOT_W-1:0] slot,
  output rd_hit_t           rd,
  output wr_hit_t           wr
);
  function automatic rd_hit_t rd_b(input logic [ADDR_W-1:0] a, input logic v);
    rd_hit_t none;
    none = '0;
    case (a)
      3'd0:    return mk_rd(R_IST0);
      3'd1:    return mk_rd(R_IST1);
      3'd2:    return mk_rd(R_ADST);
      3'd3:    return mk_rd(R_BST);
      3'd4:    return v ? mk_rd(R_IST2) : none;
      3'd5:    return v ? mk_rd(R_SPST) : none;
      3'd6:    return mk_rd(R_CPT);
      default: return mk_rd(R_DIN);
    endcase
  endfunction

  function automatic wr_hit_t slot_reg(input logic [SLOT_W-1:0] s);
    case (s)
      2'd0:    return mk_wr(W_IMK2);
      2'd1:    return mk_wr(W_EOS);
      2'd2:    return mk_wr(W_BCT);
      default: return mk_wr(W_ACC);
    endcase
  endfunction

  function automatic wr_hit_t wr_b(input logic [ADDR_W-1:0] a, input logic v,
                                   input logic [SLOT_W-1:0] s);
    wr_hit_t none;
    none = '0;
    case (a)
      3'd0:    return mk_wr(W_IMK0);
      3'd1:    return mk_wr(W_IMK1);
      3'd2:    return v ? slot_reg(s) : none;
      3'd3:    return mk_wr(W_AUX);
      3'd4:    return mk_wr(W_ADR);
      3'd5:    return mk_wr(W_SPMD);
      3'd6:    return mk_wr(W_PPL);
      default: return mk_wr(W_DOUT);
    endcase
  endfunction

  assign rd = rd_b(addr, slot_vld);
  assign wr = wr_b(addr, slot_vld, slot);
endmodule

// File: rtl/dual_map_regsel.sv
module dual_map_regsel
  import dms_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_b,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic                 dma_stb,
  input  logic                 page_pin,
  input  logic                 aux_wr,
  input  logic [CODE_W-1:0]    aux_code,
  output logic [N_RD-1:0]      rd_sel,
  output logic [N_WR-1:0]      wr_sel,
  output logic                 acc_en
);
  // named internal events for the checker
  logic              any_acc;
  logic              pga_cmd_q;
  logic              pga_open;
  logic              pgb_vld;
  logic [SLOT_W-1:0] pgb_slot;
  rd_hit_t           rd_a, rd_b, rd_m;
  wr_hit_t           wr_a, wr_b, wr_m;

  assign any_acc = rd_stb || wr_stb || dma_stb;

  dms_page_a u_pga (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .page_pin(page_pin),
    .any_acc(any_acc), .aux_wr(aux_wr), .aux_code(aux_code),
    .cmd_q(pga_cmd_q), .page_open(pga_open)
  );

  dms_page_b u_pgb (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .aux_wr(aux_wr),
    .aux_code(aux_code), .slot_vld(pgb_vld), .slot(pgb_slot)
  );

  dms_map_a u_map_a (.addr(addr), .page_open(pga_open), .rd(rd_a), .wr(wr_a));

  dms_map_b u_map_b (.addr(addr), .slot_vld(pgb_vld), .slot(pgb_slot),
                     .rd(rd_b), .wr(wr_b));

  assign rd_m = mode_b ? rd_b : rd_a;
  assign wr_m = mode_b ? wr_b : wr_a;

  for (genvar gi = 0; gi < N_RD; gi++) begin : g_rd
    assign rd_sel[gi] = rd_stb && rd_m.hit && (rd_m.idx == RIDX_W'(gi));
  end

  for (genvar gj = 0; gj < N_WR; gj++) begin : g_wr
    assign wr_sel[gj] = wr_stb && wr_m.hit && (wr_m.idx == WIDX_W'(gj));
  end

  assign acc_en = mode_b && pgb_vld;
endmodule

// File: rtl/dms_chk.sv
module dms_chk
  import dms_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_b,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              any_acc,
  input logic              aux_wr,
  input logic [CODE_W-1:0] aux_code,
  input logic              pga_cmd_q,
  input logic              pgb_vld,
  input logic [SLOT_W-1:0] pgb_slot,
  input logic [N_RD-1:0]   rd_sel,
  input logic [N_WR-1:0]   wr_sel,
  input logic              acc_en
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel) && $onehot0(wr_sel));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb |-> rd_sel == '0) and (!wr_stb |-> wr_sel == '0));

  p_cmd_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b && any_acc && !(aux_wr && aux_code == AUX_PAGE_A)) |=> !pga_cmd_q);

  p_cmd_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b && pga_cmd_q && !any_acc) |=> pga_cmd_q);

  p_pin_ign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b |-> !rd_sel[R_KST] && !rd_sel[R_SAST] && !wr_sel[W_KCT]);

  p_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_wr |=> $stable(pgb_vld) && $stable(pgb_slot));

  p_accen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> mode_b);

  p_accen_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b && !acc_en && rd_stb) |-> !rd_sel[R_IST2] && !rd_sel[R_SPST]);
endmodule

bind dual_map_regsel dms_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .any_acc(any_acc), .aux_wr(aux_wr), .aux_code(aux_code),
  .pga_cmd_q(pga_cmd_q), .pgb_vld(pgb_vld), .pgb_slot(pgb_slot),
  .rd_sel(rd_sel), .wr_sel(wr_sel), .acc_en(acc_en)
);

// File: tb/dual_map_regsel_tb.sv
module dual_map_regsel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_b = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, dma_stb = 1'b0;
  logic        page_pin = 1'b0, aux_wr = 1'b0;
  logic [2:0]  aux_code = '0;
  logic [11:0] rd_sel;
  logic [12:0] wr_sel;
  logic        acc_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  bit m_pa = 0;
  bit m_bv = 0;
  int m_bs = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_map_regsel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .addr(addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .dma_stb(dma_stb),
    .page_pin(page_pin), .aux_wr(aux_wr), .aux_code(aux_code),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .acc_en(acc_en)
  );

  // expected-register tables, indexed by offset (-1 = nothing)
  function automatic int exp_rd(bit mb, int a, bit paged, bit bv);
    int ta[8]  = '{0, 2, 3, 4, 5, 6, 7, 8};
    int tap[8] = '{0, 2, 3, 9, 5, 10, 1, 11};
    int tb[8]  = '{1, 2, 5, 11, -1, -1, 6, 0};
    if (!mb) return paged ? tap[a] : ta[a];
    if (bv && a == 4) return 3;
    if (bv && a == 5) return 4;
    return tb[a];
  endfunction

  function automatic int exp_wr(bit mb, int a, bit paged, bit bv, int bs);
    int ta[8]  = '{0, 2, 3, 4, 5, 6, 7, 8};
    int tap[8] = '{0, 2, 3, 9, 5, 6, 1, 10};
    int tb[8]  = '{1, 2, -1, 6, 7, 4, 11, 0};
    int ts[4]  = '{3, 8, 10, 12};
    if (!mb) return paged ? tap[a] : ta[a];
    if (a == 2) return bv ? ts[bs] : -1;
    return tb[a];
  endfunction

  function automatic logic [15:0] vec(int idx, bit en);
    return (en && idx >= 0) ? (16'd1 << idx) : 16'd0;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs, advance the model at posedge
  task automatic step(bit mb, int a, bit rd, bit wr, bit dma, bit pin,
                      bit aux, int code, string req);
    bit paged;
    @(negedge clk);
    mode_b = mb; addr = 3'(a); rd_stb = rd; wr_stb = wr; dma_stb = dma;
    page_pin = pin; aux_wr = aux; aux_code = 3'(code);
    #2;
    paged = !mb && (pin || m_pa);
    chk(req, "rd_sel", 16'(rd_sel), vec(exp_rd(mb, a, paged, m_bv), rd));
    chk(req, "wr_sel", 16'(wr_sel), vec(exp_wr(mb, a, paged, m_bv, m_bs), wr));
    chk("R10", "acc_en", 16'(acc_en), 16'(mb && m_bv));
    @(posedge clk);
    if (!mb) begin
      if (aux && code == 1) m_pa = 1;
      else if (rd || wr || dma) m_pa = 0;
    end else begin
      m_pa = 0;
      if (aux && code >= 4) begin m_bv = 1; m_bs = code - 4; end
      else if (aux && code == 2) m_bv = 0;
    end
  endtask

  task automatic idle(bit mb);
    step(mb, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // reset state (R11)
    #3;
    checks++;
    if (acc_en !== 1'b0 || rd_sel !== '0 || wr_sel !== '0) begin
      errors++;
      $display("FAIL R11 reset outputs: actual=%b/%h/%h expected=0/0/0", acc_en, rd_sel, wr_sel);
    end
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 base map A, every offset read and write
    for (int a = 0; a < 8; a++) step(0, a, 1, 0, 0, 0, 0, 0, "R2");
    for (int a = 0; a < 8; a++) step(0, a, 0, 1, 0, 0, 0, 0, "R2");
    // R4 pin holds the page open across accesses
    for (int a = 0; a < 8; a++) step(0, a, 1, 0, 0, 1, 0, 0, "R4");
    for (int a = 0; a < 8; a++) step(0, a, 0, 1, 0, 1, 0, 0, "R3");
    // R5 command, idle cycles keep it, then one access uses it
    step(0, 5, 0, 1, 0, 0, 1, 1, "R5");
    idle(0); idle(0);
    step(0, 3, 1, 0, 0, 0, 0, 0, "R5");   // key status (bit 9)
    step(0, 3, 1, 0, 0, 0, 0, 0, "R5");   // back to serial poll status (bit 4)
    // R5 DMA alone consumes the command
    step(0, 5, 0, 1, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R5");
    step(0, 7, 1, 0, 0, 0, 0, 0, "R5");   // addr-1, not bus status
    // R3 paged write through the command
    step(0, 5, 0, 1, 0, 0, 1, 1, "R5");
    step(0, 6, 0, 1, 0, 0, 0, 0, "R3");

    // mode B base map with pin both ways (R6, R7)
    for (int a = 0; a < 8; a++) step(1, a, 1, 0, 0, 0, 0, 0, "R6");
    for (int a = 0; a < 8; a++) step(1, a, 0, 1, 0, 1, 0, 0, "R7");
    for (int a = 0; a < 8; a++) step(1, a, 1, 0, 0, 1, 0, 0, "R7");
    // R8 each slot, held across accesses
    for (int s = 0; s < 4; s++) begin
      step(1, 3, 0, 1, 0, 0, 1, 4 + s, "R8");
      step(1, 2, 0, 1, 0, 0, 0, 0, "R8");
      step(1, 4, 1, 0, 0, 0, 0, 0, "R8");
      step(1, 5, 1, 0, 0, 0, 0, 0, "R8");
      step(1, 2, 0, 1, 0, 0, 0, 0, "R8");
    end
    // R9 replacement and clear
    step(1, 3, 0, 1, 0, 0, 1, 5, "R9");
    step(1, 3, 0, 1, 0, 0, 1, 6, "R9");
    step(1, 2, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 3, 0, 1, 0, 0, 1, 2, "R9");
    step(1, 2, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 4, 1, 0, 0, 0, 0, 0, "R9");
    // R10 acc_en goes low in mode A while slot stays mapped
    step(1, 3, 0, 1, 0, 0, 1, 7, "R10");
    idle(0);
    idle(1);

    // R11 reset mid-run with both states dirty
    step(0, 5, 0, 1, 0, 0, 1, 1, "R5");
    @(negedge clk) rst_n = 1'b0;
    #2;
    checks++;
    if (acc_en !== 1'b0) begin
      errors++;
      $display("FAIL R11 acc_en in reset: actual=%b expected=0", acc_en);
    end
    m_pa = 0; m_bv = 0; m_bs = 0;
    @(negedge clk) rst_n = 1'b1;
    step(1, 2, 0, 1, 0, 0, 0, 0, "R11");
    step(0, 3, 1, 0, 0, 0, 0, 0, "R11");

    // constrained random mix
    begin
      bit mb = 0;
      for (int n = 0; n < 4000; n++) begin
        int  r, a, code;
        bit  rd, wr, dma, pin, aux;
        string req;
        if ($urandom % 50 == 0) mb = ~mb;
        a = int'($urandom % 8);
        r = int'($urandom % 4);
        rd = (r == 1); wr = (r == 2);
        dma = ($urandom % 8 == 0);
        pin = ($urandom % 4 == 0);
        aux = ($urandom % 6 == 0);
        code = int'($urandom % 8);
        if (mb) req = m_bv ? "R8" : "R6";
        else req = (pin || m_pa) ? "R3" : "R2";
        step(mb, a, rd, wr, dma, pin, aux, code, req);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule